// File: doc/BRIEF.md
# ADC Result Window Comparator

This block watches the stream of finished analog-to-digital conversion results and flags the ones that satisfy a set of limit conditions chosen by software. Each result arrives with a one-cycle valid strobe, a 16-bit data word, the 5-bit identifier of the input channel it came from, and a flag that says whether that channel's data is two's-complement. The block does not start conversions and does not reformat data. Software writes limit values that are already in the same format as the converted data.

Three configuration registers set the behaviour. The first is a packed word holding a high limit and a low limit. The second is a control word with a global enable and five condition-enable bits. The third is a 12-bit mask that picks which inputs are watched. A result that meets any enabled condition raises an event. The event sets a sticky status bit, records the channel identifier, and produces a one-cycle interrupt pulse.

Top module: `adc_window_cmp`

## Requirements
- R1: A result is evaluated only in a cycle where `res_vld` is 1 and the enable bit (control bit 5) is 1. With either one at 0, no event is raised.
- R2: The limit register takes the high limit from `lim_wdata[31:16]` and the low limit from `lim_wdata[15:0]`. A write takes effect for results strobed from the next cycle on.
- R3: Mask bit n enables monitoring of channel n, for n = 0 to 11. A result from an unmasked channel, or from a channel identifier of 12 or more, never raises an event.
- R4: Control bit 0 enables the in-window condition: low ≤ result < high.
- R5: Control bit 1 enables the at-or-above-high condition (result ≥ high). Control bit 2 enables the below-high condition (result < high).
- R6: Control bit 3 enables the at-or-above-low condition (result ≥ low). Control bit 4 enables the below-low condition (result < low).
- R7: When `res_signed` is 1, the result and both limits are compared as two's-complement numbers. Otherwise they are compared as unsigned numbers.
- R8: The event is the OR of all enabled conditions. With control bits 4:0 all 0, no event is ever raised.
- R9: An event sets `evt_flag` and loads `evt_chan` with the result's channel identifier. A later event overwrites `evt_chan`. `evt_chan` changes only on an event.
- R10: `evt_flag` stays at 1 until `evt_clr` is strobed. A clear with no event in the same cycle drops the flag and keeps `evt_chan`. An event in the same cycle as a clear wins: the flag stays at 1 and `evt_chan` is updated.
- R11: `evt_irq` is 1 for exactly the one cycle after a strobe that raised an event, and 0 otherwise.
- R12: Reset clears `evt_flag`, `evt_chan`, `evt_irq`, both limits, the mask and the whole control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lim_we | input | 1 | Write strobe for the limit register |
| lim_wdata | input | 32 | Limit word: high limit in bits 31:16, low limit in bits 15:0 |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 6 | Bits 4:0 are the condition enables, bit 5 is the global enable |
| mask_we | input | 1 | Write strobe for the channel mask |
| mask_wdata | input | 12 | One monitor bit per channel 0 to 11 |
| res_vld | input | 1 | One-cycle strobe marking a finished conversion |
| res_data | input | 16 | Conversion result word |
| res_chan | input | 5 | Channel identifier of the result |
| res_signed | input | 1 | 1 selects a two's-complement compare for this result |
| evt_clr | input | 1 | Clear strobe for the sticky status bit |
| evt_flag | output | 1 | Sticky event-detected status |
| evt_chan | output | 5 | Channel identifier of the most recent event |
| evt_irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check the following on every cycle:
- an interrupt always follows a strobe that had the enable set and came from a channel below 12;
- the interrupt always coincides with a set status bit;
- the captured identifier equals the strobed channel and stays stable when there is no interrupt;
- the status bit falls only after a clear.

The comparison arithmetic needs a reference model: equality at each limit, signed versus unsigned ordering of the same bit pattern, and the OR of several conditions. The bench scenarios are the only check on these, as they are on the clear-versus-event priority and on reset clearing the configuration.

// File: rtl/adc_wcmp_pkg.sv
package adc_wcmp_pkg;

  // Condition enables; btwn sits at the least significant position.
  typedef struct packed {
    logic below_lo;
    logic atabove_lo;
    logic below_hi;
    logic atabove_hi;
    logic btwn;
  } cond_en_t;

  localparam int unsigned CTL_W  = $bits(cond_en_t) + 1;
  localparam int unsigned CTL_EN = $bits(cond_en_t);

endpackage

// File: rtl/adc_wcmp_rst.sv
module adc_wcmp_rst #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/adc_wcmp_cfg.sv
module adc_wcmp_cfg
  import adc_wcmp_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned NCH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lim_we,
  input  logic [2*DW-1:0]  lim_wdata,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             mask_we,
  input  logic [NCH-1:0]   mask_wdata,
  output logic [DW-1:0]    hi_lim,
  output logic [DW-1:0]    lo_lim,
  output cond_en_t         cond,
  output logic             glb_en,
  output logic [NCH-1:0]   mask
);

  logic [DW-1:0]    hi_d, lo_d;
  logic [CTL_W-1:0] ctl_q, ctl_d;
  logic [NCH-1:0]   mask_d;

  always_comb begin
    hi_d   = hi_lim;
    lo_d   = lo_lim;
    ctl_d  = ctl_q;
    mask_d = mask;
    if (lim_we) begin
      hi_d = lim_wdata[2*DW-1:DW];
      lo_d = lim_wdata[DW-1:0];
    end
    if (ctl_we)  ctl_d  = ctl_wdata;
    if (mask_we) mask_d = mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_lim <= '0;
      lo_lim <= '0;
      ctl_q  <= '0;
      mask   <= '0;
    end else begin
      hi_lim <= hi_d;
      lo_lim <= lo_d;
      ctl_q  <= ctl_d;
      mask   <= mask_d;
    end
  end

  assign cond   = cond_en_t'(ctl_q[CTL_EN-1:0]);
  assign glb_en = ctl_q[CTL_EN];

endmodule

// File: rtl/adc_wcmp_cmp.sv
module adc_wcmp_cmp
  import adc_wcmp_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned NCH = 12,
  parameter int unsigned IDW = 5
) (
  input  logic           vld,
  input  logic [DW-1:0]  data,
  input  logic [IDW-1:0] chan,
  input  logic           is_signed,
  input  logic [DW-1:0]  hi_lim,
  input  logic [DW-1:0]  lo_lim,
  input  cond_en_t       cond,
  input  logic           glb_en,
  input  logic [NCH-1:0] mask,
  output logic           hit
);

  // Extend by one bit so that a single signed comparator covers both formats.
  logic [DW:0]    ext_d, ext_hi, ext_lo;
  logic           lt_hi, lt_lo;
  logic [NCH-1:0] chan_sel;
  logic           watched;
  logic           any_cond;

  assign ext_d  = {is_signed & data[DW-1],   data};
  assign ext_hi = {is_signed & hi_lim[DW-1], hi_lim};
  assign ext_lo = {is_signed & lo_lim[DW-1], lo_lim};

  assign lt_hi = $signed(ext_d) < $signed(ext_hi);
  assign lt_lo = $signed(ext_d) < $signed(ext_lo);

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign chan_sel[g] = mask[g] && (chan == IDW'(g));
  end
  assign watched = |chan_sel;

  always_comb begin
    any_cond = 1'b0;
    if (cond.btwn       && !lt_lo && lt_hi) any_cond = 1'b1;
    if (cond.atabove_hi && !lt_hi)          any_cond = 1'b1;
    if (cond.below_hi   &&  lt_hi)          any_cond = 1'b1;
    if (cond.atabove_lo && !lt_lo)          any_cond = 1'b1;
    if (cond.below_lo   &&  lt_lo)          any_cond = 1'b1;
  end

  assign hit = vld && glb_en && watched && any_cond;

endmodule

// File: rtl/adc_wcmp_evt.sv
module adc_wcmp_evt #(
  parameter int unsigned IDW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hit,
  input  logic [IDW-1:0] chan,
  input  logic           clr,
  output logic           flag,
  output logic [IDW-1:0] id,
  output logic           irq
);

  logic           flag_d;
  logic [IDW-1:0] id_d;

  always_comb begin
    flag_d = flag;
    id_d   = id;
    if (hit) begin
      flag_d = 1'b1;
      id_d   = chan;
    end else if (clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      id   <= '0;
      irq  <= 1'b0;
    end else begin
      flag <= flag_d;
      id   <= id_d;
      irq  <= hit;
    end
  end

  assert_flag_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr));

  assert_id_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> $stable(id));

endmodule

// File: rtl/adc_window_cmp.sv
module adc_window_cmp
  import adc_wcmp_pkg::*;
#(
  parameter int unsigned DW  = 16,
  parameter int unsigned NCH = 12,
  parameter int unsigned IDW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lim_we,
  input  logic [2*DW-1:0]  lim_wdata,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             mask_we,
  input  logic [NCH-1:0]   mask_wdata,
  input  logic             res_vld,
  input  logic [DW-1:0]    res_data,
  input  logic [IDW-1:0]   res_chan,
  input  logic             res_signed,
  input  logic             evt_clr,
  output logic             evt_flag,
  output logic [IDW-1:0]   evt_chan,
  output logic             evt_irq
);

  logic           rst_n_int;
  logic [DW-1:0]  hi_lim, lo_lim;
  cond_en_t       cond;
  logic           glb_en;
  logic [NCH-1:0] mask;
  logic           hit;

  adc_wcmp_rst #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  adc_wcmp_cfg #(.DW(DW), .NCH(NCH)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .lim_we     (lim_we),
    .lim_wdata  (lim_wdata),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .hi_lim     (hi_lim),
    .lo_lim     (lo_lim),
    .cond       (cond),
    .glb_en     (glb_en),
    .mask       (mask)
  );

  adc_wcmp_cmp #(.DW(DW), .NCH(NCH), .IDW(IDW)) u_cmp (
    .vld       (res_vld),
    .data      (res_data),
    .chan      (res_chan),
    .is_signed (res_signed),
    .hi_lim    (hi_lim),
    .lo_lim    (lo_lim),
    .cond      (cond),
    .glb_en    (glb_en),
    .mask      (mask),
    .hit       (hit)
  );

  adc_wcmp_evt #(.IDW(IDW)) u_evt (
    .clk   (clk),
    .rst_n (rst_n_int),
    .hit   (hit),
    .chan  (res_chan),
    .clr   (evt_clr),
    .flag  (evt_flag),
    .id    (evt_chan),
    .irq   (evt_irq)
  );

  assert_irq_after_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    evt_irq |-> $past(res_vld));

  assert_irq_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n_int)
    evt_irq |-> $past(glb_en));

  assert_irq_chan_range_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    evt_irq |-> ($past(res_chan) < IDW'(NCH)));

  assert_irq_with_flag_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    evt_irq |-> evt_flag);

  assert_id_capture_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    evt_irq |-> (evt_chan == $past(res_chan)));

endmodule

// File: tb/adc_window_cmp_tb.sv
module adc_window_cmp_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lim_we = 1'b0;
  logic [31:0] lim_wdata = '0;
  logic        ctl_we = 1'b0;
  logic [5:0]  ctl_wdata = '0;
  logic        mask_we = 1'b0;
  logic [11:0] mask_wdata = '0;
  logic        res_vld = 1'b0;
  logic [15:0] res_data = '0;
  logic [4:0]  res_chan = '0;
  logic        res_signed = 1'b0;
  logic        evt_clr = 1'b0;
  logic        evt_flag;
  logic [4:0]  evt_chan;
  logic        evt_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench view of the configuration and status.
  logic [15:0] m_hi = '0, m_lo = '0;
  logic [5:0]  m_ctl = '0;
  logic [11:0] m_mask = '0;
  logic        m_flag = 1'b0;
  logic [4:0]  m_chan = '0;

  always #10 clk = ~clk;

  adc_window_cmp u_dut (
    .clk(clk), .rst_n(rst_n),
    .lim_we(lim_we), .lim_wdata(lim_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .res_vld(res_vld), .res_data(res_data), .res_chan(res_chan),
    .res_signed(res_signed), .evt_clr(evt_clr),
    .evt_flag(evt_flag), .evt_chan(evt_chan), .evt_irq(evt_irq)
  );

  function automatic int to_num(logic [15:0] v, logic sgn);
    if (sgn) return int'($signed(v));
    return int'({16'd0, v});
  endfunction

  function automatic logic ref_hit(logic vld, logic [15:0] d, logic [4:0] ch, logic sgn);
    int x, h, l;
    logic r;
    x = to_num(d, sgn);
    h = to_num(m_hi, sgn);
    l = to_num(m_lo, sgn);
    if (!vld || !m_ctl[5] || ch > 5'd11) return 1'b0;
    if (!m_mask[ch]) return 1'b0;
    r = 1'b0;
    if (m_ctl[0] && l <= x && x < h) r = 1'b1;
    if (m_ctl[1] && x >= h) r = 1'b1;
    if (m_ctl[2] && x <  h) r = 1'b1;
    if (m_ctl[3] && x >= l) r = 1'b1;
    if (m_ctl[4] && x <  l) r = 1'b1;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cfg_write(logic [15:0] hi, logic [15:0] lo, logic [5:0] ctl, logic [11:0] msk);
    lim_we = 1'b1; lim_wdata = {hi, lo};
    ctl_we = 1'b1; ctl_wdata = ctl;
    mask_we = 1'b1; mask_wdata = msk;
    @(negedge clk);
    lim_we = 1'b0; ctl_we = 1'b0; mask_we = 1'b0;
    m_hi = hi; m_lo = lo; m_ctl = ctl; m_mask = msk;
  endtask

  // Drive one cycle of inputs at a falling edge and check the outputs at the next one.
  task automatic step(string req, logic vld, logic [15:0] d, logic [4:0] ch, logic sgn, logic clr);
    logic exp_irq;
    res_vld = vld; res_data = d; res_chan = ch; res_signed = sgn; evt_clr = clr;
    exp_irq = ref_hit(vld, d, ch, sgn);
    @(negedge clk);
    if (exp_irq) begin
      m_flag = 1'b1;
      m_chan = ch;
    end else if (clr) begin
      m_flag = 1'b0;
    end
    chk({req, " irq"},  32'(evt_irq),  32'(exp_irq));
    chk({req, " flag"}, 32'(evt_flag), 32'(m_flag));
    chk({req, " chan"}, 32'(evt_chan), 32'(m_chan));
    res_vld = 1'b0; evt_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: outputs cleared by reset
    chk("R12 flag", 32'(evt_flag), 32'd0);
    chk("R12 chan", 32'(evt_chan), 32'd0);
    chk("R12 irq",  32'(evt_irq),  32'd0);
    // R12: configuration cleared, so even a valid result raises nothing
    step("R12 cfg", 1'b1, 16'h0000, 5'd0, 1'b0, 1'b0);

    // R2 and R4: hi=100 in [31:16], lo=10 in [15:0], in-window only, all channels
    cfg_write(16'd100, 16'd10, 6'b100001, 12'hFFF);
    step("R4 at lo",    1'b1, 16'd10,  5'd2, 1'b0, 1'b0);
    step("R4 below lo", 1'b1, 16'd9,   5'd3, 1'b0, 1'b0);
    step("R4 at hi",    1'b1, 16'd100, 5'd4, 1'b0, 1'b0);
    step("R4 hi-1",     1'b1, 16'd99,  5'd5, 1'b0, 1'b0);
    // R11: no strobe, no pulse, even with in-window data
    step("R11 no vld",  1'b0, 16'd50,  5'd6, 1'b0, 1'b0);
    // R10: plain clear drops flag and keeps channel
    step("R10 clear",   1'b1, 16'd0,   5'd7, 1'b0, 1'b1);

    // R5: at-or-above-high, then below-high (R2 places 100 as high)
    cfg_write(16'd100, 16'd10, 6'b100010, 12'hFFF);
    step("R5 R2 ge hi", 1'b1, 16'd100, 5'd8, 1'b0, 1'b0);
    step("R5 lt hi",    1'b1, 16'd99,  5'd9, 1'b0, 1'b0);
    cfg_write(16'd100, 16'd10, 6'b100100, 12'hFFF);
    step("R5 below hi", 1'b1, 16'd99,  5'd1, 1'b0, 1'b1);
    step("R5 not below",1'b1, 16'd100, 5'd2, 1'b0, 1'b1);

    // R6: at-or-above-low, then below-low
    cfg_write(16'd100, 16'd10, 6'b101000, 12'hFFF);
    step("R6 ge lo",    1'b1, 16'd10,  5'd3, 1'b0, 1'b0);
    step("R6 lt lo",    1'b1, 16'd9,   5'd4, 1'b0, 1'b1);
    cfg_write(16'd100, 16'd10, 6'b110000, 12'hFFF);
    step("R6 below lo", 1'b1, 16'd9,   5'd5, 1'b0, 1'b0);
    step("R6 not below",1'b1, 16'd10,  5'd6, 1'b0, 1'b1);

    // R7: window -16..16, data -8 hits signed, misses unsigned
    cfg_write(16'h0010, 16'hFFF0, 6'b100001, 12'hFFF);
    step("R7 signed",   1'b1, 16'hFFF8, 5'd10, 1'b1, 1'b1);
    step("R7 unsigned", 1'b1, 16'hFFF8, 5'd11, 1'b0, 1'b1);

    // R3: masked-off channel and out-of-range channel
    cfg_write(16'd100, 16'd10, 6'b100001, 12'hFF7);
    step("R3 masked",   1'b1, 16'd50, 5'd3,  1'b0, 1'b1);
    step("R3 chan12",   1'b1, 16'd50, 5'd12, 1'b0, 1'b0);
    step("R3 chan31",   1'b1, 16'd50, 5'd31, 1'b0, 1'b0);
    step("R3 watched",  1'b1, 16'd50, 5'd11, 1'b0, 1'b0);

    // R10: event in same cycle as clear wins and updates channel
    step("R10 evt+clr", 1'b1, 16'd60, 5'd0, 1'b0, 1'b1);

    // R1: global enable off
    cfg_write(16'd100, 16'd10, 6'b011111, 12'hFFF);
    step("R1 disabled", 1'b1, 16'd50, 5'd1, 1'b0, 1'b1);

    // R8: no condition selected, then OR of two disjoint conditions
    cfg_write(16'd100, 16'd10, 6'b100000, 12'hFFF);
    step("R8 none",     1'b1, 16'd50, 5'd2, 1'b0, 1'b0);
    cfg_write(16'd100, 16'd10, 6'b110010, 12'hFFF);
    step("R8 or lo",    1'b1, 16'd5,   5'd3, 1'b0, 1'b0);
    step("R8 or hi",    1'b1, 16'd200, 5'd4, 1'b0, 1'b0);
    step("R8 or gap",   1'b1, 16'd50,  5'd5, 1'b0, 1'b1);

    // R9 R11 and the rest: constrained random traffic
    for (int i = 0; i < 600; i++) begin
      logic [15:0] d;
      int sel;
      if (i % 10 == 0)
        cfg_write(16'($urandom), 16'($urandom),
                  {($urandom % 8) != 0, 5'($urandom)}, 12'($urandom));
      sel = int'($urandom % 6);
      case (sel)
        0: d = m_hi;
        1: d = m_hi - 16'd1;
        2: d = m_lo;
        3: d = m_lo - 16'd1;
        default: d = 16'($urandom);
      endcase
      step("R9 random", ($urandom % 4) != 0, d, 5'($urandom % 14),
           1'($urandom), ($urandom % 5) == 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule